// File: doc/BRIEF.md
# Amplifier Offset Trim Calibration Sequencer

This block runs the offset calibration of one analog amplifier channel with no software involvement. A single-cycle start pulse makes it switch the amplifier on, select the user trim codes over the factory ones, and then run up to four calibration passes. A 4-bit mask picks the passes. They always run in this order: normal speed with the N pair, normal speed with the P pair, high speed with the N pair, and high speed with the P pair. Each pass drives the speed-mode bit, the reference-level select and the calibration-enable line toward the analog macro.

Within a pass the sequencer steps a trim code upward from zero. After each new code it waits a settling time, given in clock cycles on an input port, and then reads the comparator flag that the amplifier produces in calibration mode. The first code at which the flag reads 0 goes into the result register for that pass. If the flag still reads 1 at the all-ones code, the sequencer stores all-ones, sets the failure bit for that pass and goes on to the next pass. When no enabled pass is left, it drops calibration mode, gives a one-cycle done pulse and returns to idle. The amplifier enable and the user-trim select stay set after the run.

Top module: `trim_cal_seq`

## Requirements
- R1: After reset every output is 0: enable, user-trim select, calibration-enable, speed bit, reference select, trim code, all four result registers, all failure bits, busy and done.
- R2: A start pulse seen in idle sets the amplifier enable in the next cycle. The user-trim select follows one cycle later. Both stay set after the run ends.
- R3: Passes run in ascending mask-bit order, and only while calibration-enable is 1. Mask bit 0 is normal/N: speed 0, reference 2'b11. Bit 1 is normal/P: speed 0, reference 2'b01. Bit 2 is high-speed/N: speed 1, reference 2'b11. Bit 3 is high-speed/P: speed 1, reference 2'b01.
- R4: Within a pass the trim code starts at 0 and rises by exactly one per step.
- R5: The comparator flag is sampled only after the code, speed and reference outputs have held steady for at least settle+1 clock cycles, where settle is the value on the settle port.
- R6: A pass ends at the first code for which the sampled flag is 0. That code is stored in the result register of that pass: result_nn for bit 0, result_np for bit 1, result_hn for bit 2, result_hp for bit 3.
- R7: A pass whose mask bit is 0 does not run. Its result register keeps its previous value and its failure bit reads 0.
- R8: If the flag is still 1 at the all-ones code, the pass stores all-ones, sets its failure bit (fail bit i for mask bit i) and moves to the next pass.
- R9: After the last enabled pass, calibration-enable drops to 0 and done is 1 for exactly one cycle, in the same cycle as calibration-enable first reads 0. Busy is 0 in the following cycle. A new start clears all failure bits.
- R10: A start pulse that arrives while busy is ignored. The run in progress completes unchanged, and no second run follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start request |
| pass_mask_i | input | 4 | Pass enables, bit 0 normal/N to bit 3 high-speed/P |
| settle_i | input | SETTLE_W | Settling wait in clock cycles |
| cmp_flag_i | input | 1 | Comparator flag from the amplifier |
| amp_en_o | output | 1 | Amplifier enable |
| user_trim_o | output | 1 | Select user trim codes |
| cal_on_o | output | 1 | Calibration mode enable |
| hs_mode_o | output | 1 | High-speed mode select |
| ref_sel_o | output | 2 | Calibration reference level select |
| trim_code_o | output | TRIM_W | Trim code under test |
| result_nn_o | output | TRIM_W | Stored code, normal/N |
| result_np_o | output | TRIM_W | Stored code, normal/P |
| result_hn_o | output | TRIM_W | Stored code, high-speed/N |
| result_hp_o | output | TRIM_W | Stored code, high-speed/P |
| fail_o | output | 4 | Per-pass failure bits |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is sampling the flag too early. The comparator settles late, so a sequencer that samples early still finishes and still stores plausible codes, only the wrong ones. The bench comparator model therefore reports a false 0 until code, speed and reference have held steady for exactly settle+1 cycles. With that model, an early sample lands on a smaller code, and the bench sees the difference in the stored results. Each pass has its own threshold, keyed on the speed bit and reference select. Sweeping every mask with those thresholds, including a threshold of 0 and thresholds beyond all-ones, exercises the pass order, the encodings, skipped passes and exhausted passes together.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;

  localparam int NPASS = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENABLE,
    ST_PICK,
    ST_WAIT,
    ST_SAMPLE,
    ST_FINISH
  } seq_state_e;

  // Pass index bit 1 selects high-speed mode.
  function automatic logic pass_is_hs(input logic [1:0] p);
    return p[1];
  endfunction

  // Pass index bit 0 selects the P pair (low reference), otherwise N pair (high reference).
  function automatic logic [1:0] pass_ref(input logic [1:0] p);
    return p[0] ? 2'b01 : 2'b11;
  endfunction

endpackage

// File: rtl/trim_settle_timer.sv
module trim_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] value_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (run_i && (cnt_q != '0));
    cnt_d  = load_i ? value_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/trim_pass_pick.sv
module trim_pass_pick #(
  parameter int NPASS = 4,
  parameter int IDX_W = 3,
  localparam int SEL_W = $clog2(NPASS)
) (
  input  logic [NPASS-1:0] mask_i,
  input  logic [IDX_W-1:0] from_i,
  output logic             found_o,
  output logic [SEL_W-1:0] idx_o
);
  // Lowest enabled pass at or above from_i; descending loop lets the lowest win.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NPASS - 1; i >= 0; i--) begin
      if (mask_i[i] && (IDX_W'(i) >= from_i)) begin
        found_o = 1'b1;
        idx_o   = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/trim_result_store.sv
module trim_result_store #(
  parameter int NPASS  = 4,
  parameter int TRIM_W = 5,
  localparam int SEL_W = $clog2(NPASS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [SEL_W-1:0]              wr_idx_i,
  input  logic [TRIM_W-1:0]             wr_code_i,
  input  logic                          wr_fail_i,
  input  logic                          fail_clr_i,
  output logic [NPASS-1:0][TRIM_W-1:0]  code_o,
  output logic [NPASS-1:0]              fail_o
);
  for (genvar g = 0; g < NPASS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   code_o[g] <= '0;
      else if (hit) code_o[g] <= wr_code_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          fail_o[g] <= 1'b0;
      else if (fail_clr_i) fail_o[g] <= 1'b0;
      else if (hit)        fail_o[g] <= wr_fail_i;
    end
  end
endmodule

// File: rtl/trim_cal_seq.sv
module trim_cal_seq
  import trim_cal_pkg::*;
#(
  parameter int TRIM_W   = 5,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [3:0]          pass_mask_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                cmp_flag_i,
  output logic                amp_en_o,
  output logic                user_trim_o,
  output logic                cal_on_o,
  output logic                hs_mode_o,
  output logic [1:0]          ref_sel_o,
  output logic [TRIM_W-1:0]   trim_code_o,
  output logic [TRIM_W-1:0]   result_nn_o,
  output logic [TRIM_W-1:0]   result_np_o,
  output logic [TRIM_W-1:0]   result_hn_o,
  output logic [TRIM_W-1:0]   result_hp_o,
  output logic [3:0]          fail_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int IDX_W = $clog2(NPASS + 1);
  localparam int SEL_W = $clog2(NPASS);
  localparam logic [TRIM_W-1:0] CODE_MAX = '1;

  seq_state_e         state_q, state_d;
  logic [IDX_W-1:0]   pidx_q, pidx_d;
  logic [TRIM_W-1:0]  code_q, code_d;
  logic               hs_q, hs_d, cal_q, cal_d, en_q, en_d, ut_q, ut_d;
  logic [1:0]         ref_q, ref_d;
  logic               tmr_load, tmr_zero, wr_en, fail_clr;
  logic               found;
  logic [SEL_W-1:0]   found_idx;
  logic [NPASS-1:0][TRIM_W-1:0] codes;

  trim_pass_pick #(.NPASS(NPASS), .IDX_W(IDX_W)) u_pick (
    .mask_i (pass_mask_i),
    .from_i (pidx_q),
    .found_o(found),
    .idx_o  (found_idx)
  );

  trim_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .run_i  (state_q == ST_WAIT),
    .value_i(settle_i),
    .zero_o (tmr_zero)
  );

  trim_result_store #(.NPASS(NPASS), .TRIM_W(TRIM_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (pidx_q[SEL_W-1:0]),
    .wr_code_i (code_q),
    .wr_fail_i (cmp_flag_i),
    .fail_clr_i(fail_clr),
    .code_o    (codes),
    .fail_o    (fail_o)
  );

  always_comb begin
    state_d  = state_q;
    pidx_d   = pidx_q;
    code_d   = code_q;
    hs_d     = hs_q;
    ref_d    = ref_q;
    cal_d    = cal_q;
    en_d     = en_q;
    ut_d     = ut_q;
    tmr_load = 1'b0;
    wr_en    = 1'b0;
    fail_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_ENABLE;
          en_d     = 1'b1;
          pidx_d   = '0;
          fail_clr = 1'b1;
        end
      end
      ST_ENABLE: begin
        ut_d    = 1'b1;
        state_d = ST_PICK;
      end
      ST_PICK: begin
        if (found) begin
          hs_d     = pass_is_hs(found_idx);
          ref_d    = pass_ref(found_idx);
          cal_d    = 1'b1;
          code_d   = '0;
          pidx_d   = IDX_W'(found_idx);
          tmr_load = 1'b1;
          state_d  = ST_WAIT;
        end else begin
          cal_d   = 1'b0;
          state_d = ST_FINISH;
        end
      end
      ST_WAIT: begin
        if (tmr_zero) state_d = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (!cmp_flag_i || (code_q == CODE_MAX)) begin
          wr_en   = 1'b1;
          pidx_d  = pidx_q + 1'b1;
          state_d = ST_PICK;
        end else begin
          code_d   = code_q + 1'b1;
          tmr_load = 1'b1;
          state_d  = ST_WAIT;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pidx_q  <= '0;
      code_q  <= '0;
      hs_q    <= 1'b0;
      ref_q   <= 2'b00;
      cal_q   <= 1'b0;
      en_q    <= 1'b0;
      ut_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pidx_q  <= pidx_d;
      code_q  <= code_d;
      hs_q    <= hs_d;
      ref_q   <= ref_d;
      cal_q   <= cal_d;
      en_q    <= en_d;
      ut_q    <= ut_d;
    end
  end

  assign amp_en_o    = en_q;
  assign user_trim_o = ut_q;
  assign cal_on_o    = cal_q;
  assign hs_mode_o   = hs_q;
  assign ref_sel_o   = ref_q;
  assign trim_code_o = code_q;
  assign result_nn_o = codes[0];
  assign result_np_o = codes[1];
  assign result_hn_o = codes[2];
  assign result_hp_o = codes[3];
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FINISH);
endmodule

// File: rtl/trim_cal_seq_chk.sv
module trim_cal_seq_chk #(
  parameter int TRIM_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              amp_en_o,
  input logic              user_trim_o,
  input logic              cal_on_o,
  input logic              hs_mode_o,
  input logic [1:0]        ref_sel_o,
  input logic [TRIM_W-1:0] trim_code_o,
  input logic [TRIM_W-1:0] result_nn_o,
  input logic [TRIM_W-1:0] result_hp_o,
  input logic [3:0]        fail_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam logic [TRIM_W-1:0] ALL1 = '1;

  a_r2_enabled_during_cal: assert property (@(posedge clk) disable iff (!rst_n)
    cal_on_o |-> (amp_en_o && user_trim_o));

  a_r3_ref_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cal_on_o |-> ((ref_sel_o == 2'b11) || (ref_sel_o == 2'b01)));

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_on_o && $past(cal_on_o) && $stable(hs_mode_o) && $stable(ref_sel_o)
     && (trim_code_o != $past(trim_code_o)))
    |-> (trim_code_o == $past(trim_code_o) + 1'b1));

  a_r4_code_zero_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_on_o) |-> (trim_code_o == '0));

  a_r8_fail_nn_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o[0]) |-> (result_nn_o == ALL1));

  a_r8_fail_hp_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o[3]) |-> (result_hp_o == ALL1));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  a_r9_done_cal_off: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!cal_on_o && busy_o));
endmodule

bind trim_cal_seq trim_cal_seq_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .amp_en_o   (amp_en_o),
  .user_trim_o(user_trim_o),
  .cal_on_o   (cal_on_o),
  .hs_mode_o  (hs_mode_o),
  .ref_sel_o  (ref_sel_o),
  .trim_code_o(trim_code_o),
  .result_nn_o(result_nn_o),
  .result_hp_o(result_hp_o),
  .fail_o     (fail_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/tb_trim_cal_seq.sv
`timescale 1ns/1ps
module tb_trim_cal_seq;
  localparam int TRIM_W   = 5;
  localparam int SETTLE_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mask = 4'h0;
  logic [SETTLE_W-1:0] settle = '0;
  logic flag = 1'b1;
  logic amp_en, user_trim, cal_on, hs, busy, done;
  logic [1:0] refs;
  logic [TRIM_W-1:0] code, r_nn, r_np, r_hn, r_hp;
  logic [3:0] fail;

  int vectors = 0;
  int errors  = 0;
  int th [4];
  int exp_trim [4];
  logic [3:0] exp_fail;

  always #10 clk = ~clk;

  trim_cal_seq #(.TRIM_W(TRIM_W), .SETTLE_W(SETTLE_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pass_mask_i(mask),
    .settle_i(settle), .cmp_flag_i(flag), .amp_en_o(amp_en),
    .user_trim_o(user_trim), .cal_on_o(cal_on), .hs_mode_o(hs),
    .ref_sel_o(refs), .trim_code_o(code), .result_nn_o(r_nn),
    .result_np_o(r_np), .result_hn_o(r_hn), .result_hp_o(r_hp),
    .fail_o(fail), .busy_o(busy), .done_o(done)
  );

  // Comparator model: reports a false 0 until settled for settle+1 cycles.
  logic [8:0] last_cfg = '0;
  int stable_cnt = 0;
  always @(negedge clk) begin
    logic [8:0] cfg;
    int pidx;
    logic truth;
    cfg = {cal_on, hs, refs, code};
    if (cfg != last_cfg) stable_cnt = 0;
    else if (stable_cnt < 100000) stable_cnt = stable_cnt + 1;
    last_cfg = cfg;
    if (refs == 2'b11)      pidx = hs ? 2 : 0;
    else if (refs == 2'b01) pidx = hs ? 3 : 1;
    else                    pidx = -1;
    truth = (pidx < 0) ? 1'b1 : (int'(code) < th[pidx]);
    flag <= (stable_cnt >= int'(settle) + 1) ? truth : 1'b0;
  end

  task automatic chk(input string req, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int result_of(input int i);
    case (i)
      0: return int'(r_nn);
      1: return int'(r_np);
      2: return int'(r_hn);
      default: return int'(r_hp);
    endcase
  endfunction

  task automatic run(input logic [3:0] m, input int s, input bit first, input bit dup);
    int guard;
    mask = m;
    settle = SETTLE_W'(s);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 enable next cycle", int'(amp_en), 1);
    if (first) chk("R2 user trim one cycle later", int'(user_trim), 0);
    @(negedge clk);
    chk("R2 user trim set", int'(user_trim), 1);
    for (int i = 0; i < 4; i++) begin
      if (m[i]) begin
        exp_trim[i] = (th[i] > 31) ? 31 : th[i];
        exp_fail[i] = (th[i] > 31);
      end else begin
        exp_fail[i] = 1'b0;
      end
    end
    guard = 0;
    while (!done && guard < 6000) begin
      if (dup && guard == 5) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    if (guard >= 6000) begin
      errors++;
      $display("FAIL R9: watchdog expired waiting for done, actual 0 expected 1");
    end
    chk("R9 done pulse", int'(done), 1);
    chk("R9 cal off at done", int'(cal_on), 0);
    @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
    chk("R9 busy cleared", int'(busy), 0);
    chk("R2 enable kept", int'(amp_en & user_trim), 1);
    for (int i = 0; i < 4; i++) begin
      if (m[i]) chk("R6 stored code (R3 order/encoding, R5 settle)", result_of(i), exp_trim[i]);
      else      chk("R7 skipped pass unchanged", result_of(i), exp_trim[i]);
      if (th[i] > 31 && m[i]) chk("R8 fail bit", int'(fail[i]), 1);
      else                    chk("R7/R8 fail bit", int'(fail[i]), int'(exp_fail[i]));
    end
    if (dup) begin
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (busy) begin
          chk("R10 no restart after ignored start", 1, 0);
          break;
        end
      end
      chk("R10 idle after run", int'(busy), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin th[i] = 40; exp_trim[i] = 0; end
    exp_fail = '0;
    repeat (3) @(negedge clk);
    chk("R1 enable", int'(amp_en), 0);
    chk("R1 cal", int'(cal_on | hs | user_trim), 0);
    chk("R1 ref/code", int'({refs, code}), 0);
    chk("R1 results", int'({r_nn, r_np, r_hn, r_hp}), 0);
    chk("R1 fail/busy/done", int'({fail, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners: immediate pass, last code, exhaustion, mid code.
    th[0] = 0; th[1] = 31; th[2] = 32; th[3] = 5;
    run(4'hF, 1, 1'b1, 1'b0);
    // R10: extra start mid-run.
    th[0] = 7; th[1] = 33; th[2] = 2; th[3] = 19;
    run(4'hF, 2, 1'b0, 1'b1);

    // Sweep every mask and several settle values.
    for (int s = 0; s < 4; s += 3) begin
      for (int m = 0; m < 16; m++) begin
        for (int i = 0; i < 4; i++) th[i] = (m * 7 + i * 11 + s * 5) % 34;
        run(4'(m), s, 1'b0, 1'b0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule